// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a multicycle processor datapath in which a single unified memory and a single ALU are reused across the steps of each instruction. It is a Moore state machine with ten states. Every instruction begins with a fetch state and a decode state. The decode state then branches on the 6-bit opcode, which is held in the instruction register, into a short path that belongs to that instruction class. Loads take five cycles, stores and register-to-register operations take four, and branch-if-equal and jump take three.

The control word for the datapath is decoded from the next state and registered, so that it always matches the state register. The outputs are the multiplexer selects, the memory strobes, the instruction-register load, the register-file write controls and the ALU mode. The only combinational output is the PC enable. It combines the unconditional PC load with the conditional PC load, and the conditional load takes effect only when the ALU zero flag is high. A debug port exposes the current state number.

Top module: `mc_ctl_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0 (`state_dbg`=0) and the outputs take the fetch-state values of R2.
- R2: State 0 (fetch) drives `mem_rd`=1, `ir_load`=1, `pc_load`=1, `alu_b_sel`=01, and 0 on `addr_sel_alu`, `alu_a_sel`, `alu_mode`, `pc_src` and every other control output. The next state is always 1.
- R3: State 1 (decode) drives `alu_b_sel`=11 and 0 on all other control outputs. It moves to state 2 for opcode 100011 (load) or 101011 (store), to state 6 for 000000 (register type), to state 8 for 000100 (branch-if-equal) and to state 9 for 000010 (jump).
- R4: A load passes through states 2, 3 and 4 and then returns to 0. State 2 drives `alu_a_sel`=1 and `alu_b_sel`=10. State 3 drives `mem_rd`=1 and `addr_sel_alu`=1. State 4 drives `rf_we`=1, `wb_sel_mem`=1 and `rf_dst_sel`=0.
- R5: A store passes through states 2 and 5 and then returns to 0. State 5 drives `mem_wr`=1 and `addr_sel_alu`=1.
- R6: A register-type instruction passes through states 6 and 7 and then returns to 0. State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10. State 7 drives `rf_we`=1, `rf_dst_sel`=1 and `wb_sel_mem`=0.
- R7: Branch-if-equal uses state 8 and then returns to 0. State 8 drives `alu_a_sel`=1, `alu_mode`=01, `pc_load_if_zero`=1 and `pc_src`=01.
- R8: Jump uses state 9 and then returns to 0. State 9 drives `pc_load`=1 and `pc_src`=10.
- R9: `pc_en` is high exactly when `pc_load` is high, or when `pc_load_if_zero` and `alu_zero` are both high. `alu_zero` has no effect on any other output.
- R10: Any opcode other than the five listed in R3 takes the machine from state 1 back to state 0.
- R11: `mem_rd` and `mem_wr` are never high together, and `rf_we` is high only in states 4 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| pc_load | output | 1 | Unconditional PC load request |
| pc_load_if_zero | output | 1 | PC load request gated by the zero flag |
| addr_sel_alu | output | 1 | Memory address select: 0 = PC, 1 = ALU output register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_sel_mem | output | 1 | Register write data select: 0 = ALU output register, 1 = memory data register |
| ir_load | output | 1 | Instruction register load |
| pc_src | output | 2 | Next-PC source: 00 ALU, 01 ALU output register, 10 jump target |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU operand A select: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B select: 00 reg B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_we | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register select: 0 = rt field, 1 = rd field |
| pc_en | output | 1 | Combined PC enable |
| state_dbg | output | 4 | Current state number |

## Verification
The assertions assume that `opcode` holds steady from the decode state through the address-computation state, as it does when it comes from an instruction register loaded only during fetch. They also assume that `alu_zero` is a clean 0 or 1 whenever the machine is in the branch state. The stimulus changes `opcode` and `alu_zero` only while the machine is in the fetch state of a new instruction, a few nanoseconds after the clock edge, and keeps both steady until that instruction has finished. The sequence covers every instruction class, both values of the zero flag for branches, the zero flag held high during instructions that must ignore it, and an undefined opcode.

// File: rtl/mc_ctl_pkg.sv
package mc_ctl_pkg;
  localparam int OPC_W = 6;
  localparam int ST_W  = 4;
  localparam int SEL_W = 2;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MREAD  = 4'd3,
    S_MWB    = 4'd4,
    S_MWRITE = 4'd5,
    S_EXEC   = 4'd6,
    S_RDONE  = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } st_e;

  typedef struct packed {
    logic             pc_load;
    logic             pc_cond;
    logic             addr_alu;
    logic             mem_rd;
    logic             mem_wr;
    logic             wb_mem;
    logic             ir_load;
    logic [SEL_W-1:0] pc_src;
    logic [SEL_W-1:0] alu_mode;
    logic             a_sel;
    logic [SEL_W-1:0] b_sel;
    logic             rf_we;
    logic             rf_dst;
  } ctl_t;
endpackage

// File: rtl/mc_ctl_next.sv
module mc_ctl_next
  import mc_ctl_pkg::*;
(
  input  st_e              cur,
  input  logic [OPC_W-1:0] opc,
  output st_e              nxt
);
  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (opc)
          OPC_LOAD, OPC_STORE: nxt = S_MADDR;
          OPC_RTYPE:           nxt = S_EXEC;
          OPC_BEQ:             nxt = S_BRANCH;
          OPC_JUMP:            nxt = S_JUMP;
          default:             nxt = S_FETCH;
        endcase
      end
      S_MADDR:  nxt = (opc == OPC_STORE) ? S_MWRITE : S_MREAD;
      S_MREAD:  nxt = S_MWB;
      S_EXEC:   nxt = S_RDONE;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctl_decode.sv
module mc_ctl_decode
  import mc_ctl_pkg::*;
(
  input  st_e  st,
  output ctl_t ctl
);
  always_comb begin
    ctl = '0;
    case (st)
      S_FETCH: begin
        ctl.mem_rd  = 1'b1;
        ctl.ir_load = 1'b1;
        ctl.pc_load = 1'b1;
        ctl.b_sel   = 2'b01;
      end
      S_DECODE: ctl.b_sel = 2'b11;
      S_MADDR: begin
        ctl.a_sel = 1'b1;
        ctl.b_sel = 2'b10;
      end
      S_MREAD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      S_MWB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_mem = 1'b1;
      end
      S_MWRITE: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_alu = 1'b1;
      end
      S_EXEC: begin
        ctl.a_sel    = 1'b1;
        ctl.alu_mode = 2'b10;
      end
      S_RDONE: begin
        ctl.rf_we  = 1'b1;
        ctl.rf_dst = 1'b1;
      end
      S_BRANCH: begin
        ctl.a_sel    = 1'b1;
        ctl.alu_mode = 2'b01;
        ctl.pc_cond  = 1'b1;
        ctl.pc_src   = 2'b01;
      end
      S_JUMP: begin
        ctl.pc_load = 1'b1;
        ctl.pc_src  = 2'b10;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctl_seq.sv
module mc_ctl_seq
  import mc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic             pc_load,
  output logic             pc_load_if_zero,
  output logic             addr_sel_alu,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wb_sel_mem,
  output logic             ir_load,
  output logic [SEL_W-1:0] pc_src,
  output logic [SEL_W-1:0] alu_mode,
  output logic             alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic             rf_we,
  output logic             rf_dst_sel,
  output logic             pc_en,
  output logic [ST_W-1:0]  state_dbg
);
  st_e  state_q;
  st_e  state_nx;
  st_e  state_d;
  ctl_t ctl_d;
  ctl_t ctl_q;

  mc_ctl_next u_next (
    .cur (state_q),
    .opc (opcode),
    .nxt (state_nx)
  );

  assign state_d = rst ? S_FETCH : state_nx;

  // Decode from the next state so the registered word lines up with state_q
  mc_ctl_decode u_dec (
    .st  (state_d),
    .ctl (ctl_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    ctl_q   <= ctl_d;
  end

  assign pc_load         = ctl_q.pc_load;
  assign pc_load_if_zero = ctl_q.pc_cond;
  assign addr_sel_alu    = ctl_q.addr_alu;
  assign mem_rd          = ctl_q.mem_rd;
  assign mem_wr          = ctl_q.mem_wr;
  assign wb_sel_mem      = ctl_q.wb_mem;
  assign ir_load         = ctl_q.ir_load;
  assign pc_src          = ctl_q.pc_src;
  assign alu_mode        = ctl_q.alu_mode;
  assign alu_a_sel       = ctl_q.a_sel;
  assign alu_b_sel       = ctl_q.b_sel;
  assign rf_we           = ctl_q.rf_we;
  assign rf_dst_sel      = ctl_q.rf_dst;
  assign pc_en           = ctl_q.pc_load | (ctl_q.pc_cond & alu_zero);
  assign state_dbg       = state_q;

  assert_reset_fetch_R1: assert property (@(posedge clk)
    rst |=> (state_dbg == 4'd0 && ir_load && pc_load));

  assert_fetch_next_R2: assert property (@(posedge clk) disable iff (rst)
    state_q == S_FETCH |=> state_q == S_DECODE);

  assert_dispatch_beq_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && opcode == OPC_BEQ) |=> state_dbg == 4'd8);

  assert_load_wb_R4: assert property (@(posedge clk) disable iff (rst)
    state_q == S_MREAD |=> (rf_we && wb_sel_mem));

  assert_store_done_R5: assert property (@(posedge clk) disable iff (rst)
    state_q == S_MWRITE |=> state_q == S_FETCH);

  assert_rtype_done_R6: assert property (@(posedge clk) disable iff (rst)
    state_q == S_EXEC |=> (rf_we && rf_dst_sel));

  assert_branch_done_R7: assert property (@(posedge clk) disable iff (rst)
    pc_load_if_zero |=> state_q == S_FETCH);

  assert_jump_done_R8: assert property (@(posedge clk) disable iff (rst)
    state_q == S_JUMP |=> state_q == S_FETCH);

  assert_pc_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (pc_load_if_zero && !alu_zero) |-> !pc_en);

  assert_bad_opcode_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && opcode != OPC_LOAD && opcode != OPC_STORE &&
     opcode != OPC_RTYPE && opcode != OPC_BEQ && opcode != OPC_JUMP)
    |=> state_q == S_FETCH);

  assert_mem_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_rf_we_state_R11: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (state_q == S_MWB || state_q == S_RDONE));
endmodule

// File: tb/mc_ctl_seq_test.sv
module mc_ctl_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic       alu_zero = 1'b0;
  logic       pc_load, pc_load_if_zero, addr_sel_alu, mem_rd, mem_wr;
  logic       wb_sel_mem, ir_load, alu_a_sel, rf_we, rf_dst_sel, pc_en;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic [3:0] state_dbg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [3:0]  st;
    logic [15:0] ctl;
    logic        pen;
  } exp_t;

  exp_t  eq[$];
  string tq[$];

  always #10 clk = ~clk;

  mc_ctl_seq uut (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .pc_load(pc_load), .pc_load_if_zero(pc_load_if_zero),
    .addr_sel_alu(addr_sel_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .wb_sel_mem(wb_sel_mem), .ir_load(ir_load), .pc_src(pc_src),
    .alu_mode(alu_mode), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .rf_we(rf_we), .rf_dst_sel(rf_dst_sel), .pc_en(pc_en),
    .state_dbg(state_dbg)
  );

  // Order: pc_load, cond, addr, rd, wr, wbmem, irload, pc_src, alu_mode, a, b, we, dst
  function automatic logic [15:0] exp_ctl(input logic [3:0] st);
    case (st)
      4'd0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0};
      4'd1: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0};
      4'd2: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,2'b10,1'b0,1'b0};
      4'd3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
      4'd4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0};
      4'd5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0};
      4'd6: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,1'b1,2'b00,1'b0,1'b0};
      4'd7: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1};
      4'd8: return {1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,1'b1,2'b00,1'b0,1'b0};
      4'd9: return {1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'b00,1'b0,2'b00,1'b0,1'b0};
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] act_ctl();
    return {pc_load, pc_load_if_zero, addr_sel_alu, mem_rd, mem_wr, wb_sel_mem,
            ir_load, pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_we, rf_dst_sel};
  endfunction

  task automatic push(input logic [3:0] st, input logic z, input string tag);
    exp_t e;
    logic [15:0] c;
    c = exp_ctl(st);
    e.st  = st;
    e.ctl = c;
    e.pen = c[15] | (c[14] & z);
    eq.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic compare(input exp_t e, input string tag);
    checks++;
    if (state_dbg !== e.st || act_ctl() !== e.ctl || pc_en !== e.pen) begin
      fails++;
      $display("FAIL %s: state=%0d ctl=%h pc_en=%b expected state=%0d ctl=%h pc_en=%b",
               tag, state_dbg, act_ctl(), pc_en, e.st, e.ctl, e.pen);
    end
  endtask

  // Driver: called during a fetch cycle, pushes the whole expected path
  task automatic run_instr(input logic [5:0] opc, input logic z, input string ftag);
    opcode   = opc;
    alu_zero = z;
    push(4'd0, z, ftag);
    push(4'd1, z, "R3 decode");
    case (opc)
      6'b100011: begin
        push(4'd2, z, "R4 addr");
        push(4'd3, z, "R4 R11 read");
        push(4'd4, z, "R4 R9 writeback");
      end
      6'b101011: begin
        push(4'd2, z, "R5 addr");
        push(4'd5, z, "R5 R11 write");
      end
      6'b000000: begin
        push(4'd6, z, "R6 R9 exec");
        push(4'd7, z, "R6 R11 done");
      end
      6'b000100: push(4'd8, z, "R7 R9 branch");
      6'b000010: push(4'd9, z, "R8 jump");
      default: ;
    endcase
    wait (eq.size() == 0);
    @(posedge clk);
    #2;
  endtask

  // Monitor: one expected item per cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (eq.size() > 0) begin
      exp_t  e;
      string t;
      e = eq.pop_front();
      t = tq.pop_front();
      compare(e, t);
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    exp_t r;
    repeat (2) @(posedge clk);
    @(negedge clk);
    r.st = 4'd0; r.ctl = exp_ctl(4'd0); r.pen = 1'b1;
    compare(r, "R1 reset");
    @(negedge clk);
    compare(r, "R1 reset held");
    @(posedge clk);
    #2;
    rst = 1'b0;
    run_instr(6'b100011, 1'b0, "R2 fetch lw");
    run_instr(6'b101011, 1'b0, "R2 fetch sw");
    run_instr(6'b000000, 1'b0, "R2 fetch rtype");
    run_instr(6'b000100, 1'b1, "R2 R9 fetch beq taken");
    run_instr(6'b000100, 1'b0, "R2 fetch beq not taken");
    run_instr(6'b000010, 1'b0, "R2 fetch j");
    run_instr(6'b111111, 1'b0, "R2 fetch bad");
    run_instr(6'b000000, 1'b1, "R10 back to fetch");
    run_instr(6'b100011, 1'b1, "R2 R9 fetch lw zero");
    run_instr(6'b101011, 1'b1, "R2 R9 fetch sw zero");
    run_instr(6'b000001, 1'b1, "R2 fetch bad2");
    run_instr(6'b000010, 1'b1, "R10 R8 fetch j");
    // Reset in the middle of a load returns to fetch
    opcode = 6'b100011;
    repeat (2) @(posedge clk);
    #2;
    rst = 1'b1;
    @(posedge clk);
    #2;
    rst = 1'b0;
    @(negedge clk);
    r.st = 4'd0; r.ctl = exp_ctl(4'd0); r.pen = 1'b1;
    compare(r, "R1 mid reset");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule